// File: doc/BRIEF.md
# Multi-Target Mailbox Send Side

This block is the sending half of an inter-core mailbox. A local host composes a 64-bit message by writing a low word and a high word into holding registers. It then writes a destination number from 0 to 7, and writes a go command that appends the message to that destination's private queue. Each destination has a four-entry queue. A simple fetch port stands in for the remote cores: a destination pulls the oldest entry from its queue through this port.

For every destination the block keeps three indications, packed one byte each into a single status word:
- pending: the queue still holds an unfetched message;
- fetched: the destination has taken a message;
- dropped: a go command arrived while the queue was full.

The fetched and dropped flags are sticky. They are cleared by writing ones to a separate flag-clear register. A single interrupt line combines three sources, each with its own mask bit: queue full, any dropped flag, and any fetched flag. The interrupt latches until software clears it.

Reads are combinational from the current address. Writes take effect at the next clock edge. Only one bus write happens per cycle, and only one fetch per cycle.

Top module: `mbx_inbox`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0, the mask register (0x1C) reads 0x7, the depth register (0x24) reads DEPTH-1 = 3, `irq` is 0 and `fetch_valid` is 0.
- R2: Writes to the destination register (0x00, bits 2:0), the low word (0x04) and the high word (0x08) are captured at the next edge and read back unchanged from the same offsets.
- R3: A write to 0x0C with bit 0 = 1 appends {high word, low word} to the queue of the captured destination; bit 0 = 0 has no effect. The fetch port presents the oldest entry of the queue selected by `fetch_id` on `fetch_data`, in first-in first-out order.
- R4: Status bits 7:0 hold one pending bit per destination, equal to "queue not empty". The bit sets at the edge that appends the entry and clears at the edge that fetches the last one; `fetch_valid` is the pending bit of `fetch_id`.
- R5: A fetch (`fetch_en` = 1) from a non-empty queue removes its head and sets the destination's fetched flag, status bit 16+id. A fetch from an empty queue changes nothing.
- R6: A go command toward a queue holding 4 entries drops the message and sets the dropped flag, status bit 8+id. It counts as full even if a fetch of that queue happens in the same cycle; that fetch still takes place.
- R7: A write to 0x10 clears each fetched flag whose bit in 23:16 is 1 and each dropped flag whose bit in 15:8 is 1. A flag-setting event in the same cycle wins over the clear.
- R8: Mask bits at 0x1C are: bit 0 queue-full source (any queue full), bit 1 dropped source (any dropped flag), bit 2 fetched source (any fetched flag). A 1 masks the source. `irq` rises at the edge after an unmasked source is active and then stays high.
- R9: Writing 1 to bit 0 of 0x18 forces `irq` low at that edge. It rises again at the next edge if an unmasked source is still active. Bit 0 of 0x18 reads the current `irq`.
- R10: Offset 0x20 reads 0 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| fetch_en | input | 1 | Remote fetch strobe |
| fetch_id | input | 3 | Destination performing the fetch |
| fetch_valid | output | 1 | Queue of `fetch_id` is non-empty |
| fetch_data | output | 64 | Head entry of the queue of `fetch_id` |
| irq | output | 1 | Latched interrupt |

## Verification
Register contents, queue contents, pending bits and sticky flags change at the first edge after the write or fetch that causes them. Read data and the fetch head therefore follow one cycle after the stimulus. The interrupt depends on the registered flags, so it is due one edge later still: two edges after a fetch or a drop, and one edge after a mask change.

The bench drives inputs at the falling edge and advances its reference model at the rising edge. It compares the model 2 ns after each rising edge. Directed checks sample at the falling edge that follows the causing edge; interrupt checks wait one extra cycle wherever the flag stage sits in between.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // register byte offsets
    typedef enum logic [5:0] {
        A_TGT   = 6'h00,
        A_LO    = 6'h04,
        A_HI    = 6'h08,
        A_GO    = 6'h0C,
        A_FCLR  = 6'h10,
        A_STAT  = 6'h14,
        A_IRQ   = 6'h18,
        A_MASK  = 6'h1C,
        A_LOCK  = 6'h20,
        A_DEPTH = 6'h24
    } reg_addr_e;

    // interrupt source positions (also mask bit positions)
    localparam int SRC_FULL = 0;
    localparam int SRC_DROP = 1;
    localparam int SRC_DONE = 2;
    localparam int NSRC     = 3;

    // byte-wide status fields: pending, dropped, fetched
    localparam int FLD_W = 8;
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_q, q_d;
    logic do_push, do_pop;

    always_comb begin
        q_d     = q_q;
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push && (q_q.cnt != CW'(DEPTH));
        if (do_push) begin
            q_d.mem[q_q.wp] = wdata;
            q_d.wp = (q_q.wp == PW'(DEPTH - 1)) ? '0 : q_q.wp + 1'b1;
        end
        if (do_pop) begin
            q_d.rp = (q_q.rp == PW'(DEPTH - 1)) ? '0 : q_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.mem[q_q.rp];
    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CW'(DEPTH));

    // R3: a fetch without a simultaneous append removes exactly one entry
    assert_pop_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (q_q.cnt == $past(q_q.cnt) - 1'b1));

    // R6: an append into a full queue without a fetch leaves it full
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);

    // R6: occupancy never passes the depth
    assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
    parameter int NS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src,
    input  logic [NS-1:0] mask,
    input  logic          clr,
    output logic          irq
);
    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t s_q, s_d;
    logic active;

    always_comb begin
        s_d    = s_q;
        active = |(src & ~mask);
        if (clr)         s_d.pend = 1'b0;
        else if (active) s_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.pend;

    // R9: a clear request always drops the line at that edge
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !irq);

    // R8: the line only rises because an unmasked source was active
    assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(src & ~mask)));

    // R8: once high, the line holds while no clear arrives
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
endmodule

// File: rtl/mbx_inbox.sv
module mbx_inbox #(
    parameter int NUM_TGT = 8,
    parameter int DEPTH   = 4,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic                       fetch_en,
    input  logic [$clog2(NUM_TGT)-1:0] fetch_id,
    output logic                       fetch_valid,
    output logic [2*WORD_W-1:0]        fetch_data,
    output logic                       irq
);
    import mbx_pkg::*;

    localparam int ID_W  = $clog2(NUM_TGT);
    localparam int MSG_W = 2 * WORD_W;

    typedef struct packed {
        logic [ID_W-1:0]    tgt;
        logic [WORD_W-1:0]  lo;
        logic [WORD_W-1:0]  hi;
        logic [NUM_TGT-1:0] done;
        logic [NUM_TGT-1:0] drop;
        logic [NSRC-1:0]    mask;
    } regs_t;

    regs_t q, d;

    logic [NUM_TGT-1:0] push, pop, empty, full, busy;
    logic [NUM_TGT-1:0] done_set, drop_set, done_clr, drop_clr;
    logic [MSG_W-1:0]   heads [NUM_TGT];
    logic               go, irq_clr;
    logic [NSRC-1:0]    src;

    always_comb begin
        d        = q;
        go       = bus_wr && (bus_addr == ADDR_W'(A_GO)) && bus_wdata[0];
        irq_clr  = bus_wr && (bus_addr == ADDR_W'(A_IRQ)) && bus_wdata[0];
        done_clr = '0;
        drop_clr = '0;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(A_TGT):  d.tgt  = bus_wdata[ID_W-1:0];
                ADDR_W'(A_LO):   d.lo   = bus_wdata;
                ADDR_W'(A_HI):   d.hi   = bus_wdata;
                ADDR_W'(A_MASK): d.mask = bus_wdata[NSRC-1:0];
                ADDR_W'(A_FCLR): begin
                    done_clr = bus_wdata[2*FLD_W +: NUM_TGT];
                    drop_clr = bus_wdata[FLD_W +: NUM_TGT];
                end
                default: ;
            endcase
        end
        for (int t = 0; t < NUM_TGT; t++) begin
            push[t] = go && (q.tgt == ID_W'(t));
            pop[t]  = fetch_en && (fetch_id == ID_W'(t));
        end
        done_set = pop & busy;
        drop_set = push & full;
        d.done   = (q.done & ~done_clr) | done_set;
        d.drop   = (q.drop & ~drop_clr) | drop_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        mbx_queue #(.DEPTH(DEPTH), .W(MSG_W)) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[g]),
            .wdata ({q.hi, q.lo}),
            .pop   (pop[g]),
            .head  (heads[g]),
            .empty (empty[g]),
            .full  (full[g])
        );
        assign busy[g] = ~empty[g];
    end

    always_comb begin
        src           = '0;
        src[SRC_FULL] = |full;
        src[SRC_DROP] = |q.drop;
        src[SRC_DONE] = |q.done;
    end

    mbx_irq_ctrl #(.NS(NSRC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .mask  (q.mask),
        .clr   (irq_clr),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_TGT):   bus_rdata[ID_W-1:0] = q.tgt;
            ADDR_W'(A_LO):    bus_rdata = q.lo;
            ADDR_W'(A_HI):    bus_rdata = q.hi;
            ADDR_W'(A_STAT): begin
                bus_rdata[NUM_TGT-1:0]           = busy;
                bus_rdata[FLD_W +: NUM_TGT]      = q.drop;
                bus_rdata[2*FLD_W +: NUM_TGT]    = q.done;
            end
            ADDR_W'(A_IRQ):   bus_rdata[0] = irq;
            ADDR_W'(A_MASK):  bus_rdata[NSRC-1:0] = q.mask;
            ADDR_W'(A_DEPTH): bus_rdata = WORD_W'(DEPTH - 1);
            default: ;
        endcase
    end

    assign fetch_valid = busy[fetch_id];
    assign fetch_data  = heads[fetch_id];

    // R6: a go command toward a full queue records a drop
    assert_drop_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && full[q.tgt]) |=> q.drop[$past(q.tgt)]);

    // R5 / R7: a fetch from a non-empty queue leaves the fetched flag set
    assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && fetch_valid) |=> q.done[$past(fetch_id)]);

    // R4: an accepted append makes the destination pending
    assert_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !full[q.tgt]) |=> busy[$past(q.tgt)]);

    // R10: the lock offset never returns data
    assert_lock_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_LOCK)) |-> (bus_rdata == '0));
endmodule

// File: tb/test_mbx_inbox.sv
module test_mbx_inbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fetch_en = 1'b0;
    logic [2:0]  fetch_id = '0;
    logic        fetch_valid;
    logic [63:0] fetch_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbx_inbox i_mbx_inbox (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fetch_en(fetch_en),
        .fetch_id(fetch_id), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] mq [8][$];
    logic [2:0]  m_tgt;
    logic [31:0] m_lo, m_hi;
    logic [7:0]  m_done, m_drop;
    logic [2:0]  m_mask;
    bit          m_irq;

    function automatic logic [7:0] m_busy();
        logic [7:0] b;
        for (int t = 0; t < 8; t++) b[t] = (mq[t].size() > 0);
        return b;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        case (a)
            6'h00: return {29'd0, m_tgt};
            6'h04: return m_lo;
            6'h08: return m_hi;
            6'h14: return {8'd0, m_done, m_drop, m_busy()};
            6'h18: return {31'd0, m_irq};
            6'h1C: return {29'd0, m_mask};
            6'h24: return 32'd3;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 8; t++) mq[t].delete();
            m_tgt = 0; m_lo = 0; m_hi = 0; m_done = 0; m_drop = 0;
            m_mask = 3'h7; m_irq = 0;
        end else begin
            bit          anyfull, src_on, go;
            logic [7:0]  dset, oset, dclr, oclr;
            int          sz_tgt;
            anyfull = 0;
            for (int t = 0; t < 8; t++) if (mq[t].size() == 4) anyfull = 1;
            src_on = (anyfull && !m_mask[0]) || ((m_drop != 0) && !m_mask[1]) ||
                     ((m_done != 0) && !m_mask[2]);
            go = bus_wr && bus_addr == 6'h0C && bus_wdata[0];
            sz_tgt = mq[m_tgt].size();
            dset = 0; oset = 0; dclr = 0; oclr = 0;
            if (fetch_en && mq[fetch_id].size() > 0) begin
                void'(mq[fetch_id].pop_front());
                dset[fetch_id] = 1;
            end
            if (go) begin
                if (sz_tgt == 4) oset[m_tgt] = 1;
                else mq[m_tgt].push_back({m_hi, m_lo});
            end
            if (bus_wr && bus_addr == 6'h10) begin
                dclr = bus_wdata[23:16];
                oclr = bus_wdata[15:8];
            end
            m_done = (m_done & ~dclr) | dset;
            m_drop = (m_drop & ~oclr) | oset;
            if (bus_wr && bus_addr == 6'h18 && bus_wdata[0]) m_irq = 0;
            else if (src_on) m_irq = 1;
            if (bus_wr) begin
                case (bus_addr)
                    6'h00: m_tgt = bus_wdata[2:0];
                    6'h04: m_lo = bus_wdata;
                    6'h08: m_hi = bus_wdata;
                    6'h1C: m_mask = bus_wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq) begin
                failures++;
                $display("FAIL R8 model irq: got %0b expected %0b", irq, m_irq);
            end
            checks++;
            if (fetch_valid !== (mq[fetch_id].size() > 0)) begin
                failures++;
                $display("FAIL R4 model fetch_valid: got %0b expected %0b",
                         fetch_valid, mq[fetch_id].size() > 0);
            end
            if (mq[fetch_id].size() > 0) begin
                checks++;
                if (fetch_data !== mq[fetch_id][0]) begin
                    failures++;
                    $display("FAIL R3 model fetch_data: got %h expected %h",
                             fetch_data, mq[fetch_id][0]);
                end
            end
            checks++;
            if (bus_rdata !== m_read(bus_addr)) begin
                failures++;
                $display("FAIL R2 model rdata@%h: got %h expected %h",
                         bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // ---------------- stimulus helpers (entered and left at a falling edge) ----
    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] v);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic fetch(logic [2:0] id);
        fetch_en = 1; fetch_id = id;
        @(negedge clk);
        fetch_en = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(6'h14, v); chk("R1 status", v, 0);
        rd(6'h1C, v); chk("R1 mask", v, 32'h7);
        rd(6'h24, v); chk("R1 depth", v, 32'h3);
        chk("R1 irq", irq, 0);
        chk("R1 fetch_valid", fetch_valid, 0);

        // R2 holding registers
        @(negedge clk);
        wr(6'h00, 32'd5);
        wr(6'h04, 32'hA5A5_0001);
        wr(6'h08, 32'h5A5A_0001);
        rd(6'h00, v); chk("R2 target", v, 32'd5);
        rd(6'h04, v); chk("R2 low", v, 32'hA5A5_0001);
        rd(6'h08, v); chk("R2 high", v, 32'h5A5A_0001);

        // R10 lock offset
        @(negedge clk);
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, v); chk("R10 lock", v, 0);
        rd(6'h14, v); chk("R10 no side effect", v, 0);

        // R3 / R4 / R5 queue order and flags
        @(negedge clk);
        wr(6'h0C, 32'd1);
        wr(6'h04, 32'hA5A5_0002);
        wr(6'h08, 32'h5A5A_0002);
        wr(6'h0C, 32'd1);
        wr(6'h0C, 32'd0);
        rd(6'h14, v); chk("R4 pending bit 5", v, 32'h0000_0020);
        fetch_id = 3'd5; #1;
        chk("R4 fetch_valid", fetch_valid, 1);
        chk("R3 first entry", fetch_data, 64'h5A5A0001_A5A50001);
        @(negedge clk);
        fetch(3'd5);
        rd(6'h14, v); chk("R5 fetched flag 5", v, 32'h0020_0020);
        chk("R3 second entry", fetch_data, 64'h5A5A0002_A5A50002);
        @(negedge clk);
        fetch(3'd5);
        rd(6'h14, v); chk("R4 pending clears, R3 bit0=0 ignored", v, 32'h0020_0000);
        chk("R4 fetch_valid low", fetch_valid, 0);
        @(negedge clk);
        fetch(3'd5);
        rd(6'h14, v); chk("R5 empty fetch ignored", v, 32'h0020_0000);
        chk("R8 masked irq", irq, 0);

        // R7 flag clear
        @(negedge clk);
        wr(6'h10, 32'h00FF_FF00);
        rd(6'h14, v); chk("R7 clear", v, 0);

        // R6 overflow on a full queue
        @(negedge clk);
        wr(6'h00, 32'd2);
        for (int k = 1; k <= 5; k++) begin
            wr(6'h04, k);
            wr(6'h08, 32'hB000_0000 | k);
            wr(6'h0C, 32'd1);
        end
        rd(6'h14, v); chk("R6 drop flag 2", v, 32'h0000_0404);
        fetch_id = 3'd2;
        for (int k = 1; k <= 4; k++) begin
            #1;
            chk("R6 kept entries in order", fetch_data,
                {32'hB000_0000 | k, 32'(k)});
            @(negedge clk);
            fetch(3'd2);
        end
        #1;
        chk("R6 fifth entry dropped", fetch_valid, 0);
        rd(6'h14, v); chk("R6 status after drain", v, 32'h0004_0400);

        // R6 full queue with a simultaneous fetch still drops
        @(negedge clk);
        wr(6'h10, 32'h00FF_FF00);
        for (int k = 6; k <= 9; k++) begin
            wr(6'h04, k);
            wr(6'h08, 32'hB000_0000 | k);
            wr(6'h0C, 32'd1);
        end
        wr(6'h04, 32'd10);
        wr(6'h08, 32'hB000_000A);
        bus_wr = 1; bus_addr = 6'h0C; bus_wdata = 32'd1;
        fetch_en = 1; fetch_id = 3'd2;
        @(negedge clk);
        bus_wr = 0; fetch_en = 0;
        rd(6'h14, v); chk("R6 drop with fetch", v, 32'h0004_0404);
        for (int k = 7; k <= 9; k++) begin
            #1;
            chk("R6 remaining entries", fetch_data, {32'hB000_0000 | k, 32'(k)});
            @(negedge clk);
            fetch(3'd2);
        end
        #1;
        chk("R6 no entry appended", fetch_valid, 0);

        // R7 set wins over clear in the same cycle
        @(negedge clk);
        wr(6'h10, 32'h00FF_FF00);
        wr(6'h00, 32'd3);
        wr(6'h0C, 32'd1);
        bus_wr = 1; bus_addr = 6'h10; bus_wdata = 32'h00FF_FF00;
        fetch_en = 1; fetch_id = 3'd3;
        @(negedge clk);
        bus_wr = 0; fetch_en = 0;
        rd(6'h14, v); chk("R7 set wins", v, 32'h0008_0000);

        // R8 fetched source
        chk("R8 still masked", irq, 0);
        @(negedge clk);
        wr(6'h1C, 32'h3);
        chk("R8 irq one edge after unmask", irq, 0);
        @(negedge clk);
        chk("R8 fetched source raises irq", irq, 1);
        rd(6'h18, v); chk("R9 status reads irq", v, 1);

        // R9 clear with sources gone
        @(negedge clk);
        wr(6'h10, 32'h00FF_FF00);
        wr(6'h18, 32'd1);
        repeat (2) @(negedge clk);
        chk("R9 stays low", irq, 0);

        // R9 clear while source active re-rises
        wr(6'h0C, 32'd1);
        fetch(3'd3);
        @(negedge clk);
        chk("R9 raised again", irq, 1);
        wr(6'h18, 32'd1);
        chk("R9 forced low at clear edge", irq, 0);
        @(negedge clk);
        chk("R9 re-rise next edge", irq, 1);

        // R8 queue-full source only
        wr(6'h10, 32'h00FF_FF00);
        wr(6'h1C, 32'h6);
        wr(6'h18, 32'd1);
        @(negedge clk);
        chk("R8 cleared before full test", irq, 0);
        wr(6'h00, 32'd1);
        for (int k = 0; k < 4; k++) wr(6'h0C, 32'd1);
        chk("R8 full not yet seen", irq, 0);
        @(negedge clk);
        chk("R8 full source raises irq", irq, 1);

        // R8 dropped source only
        wr(6'h1C, 32'h5);
        wr(6'h18, 32'd1);
        @(negedge clk);
        chk("R8 full now masked", irq, 0);
        wr(6'h0C, 32'd1);
        rd(6'h14, v); chk("R6 drop flag 1", v, 32'h0000_0202);
        @(negedge clk);
        chk("R8 dropped source raises irq", irq, 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule